// File: doc/BRIEF.md
# Single-Cycle Register Add/Subtract Core

This block is a small processor core that runs one instruction per clock cycle from a fixed program. Each instruction is a 32-bit word in the standard three-register format. A 4-bit program counter selects one of sixteen words in a read-only program store. The word is decoded, two source registers are read from a 32-entry register file, and a ripple-carry chain either adds the two operands or subtracts the second from the first. On the next rising edge the result goes into the destination register and the program counter moves on.

The program image and the power-up contents of the register file are both elaboration-time parameters. The core has no data memory and no control flow, so the program counter simply cycles through the store. The current program counter, the value being produced by the instruction at that address, and the carry-out of the arithmetic chain are brought out so that the program can be followed from the outside.

Top module: `rtcore_addsub`

## Requirements
- R1: An instruction word is split from bit 31 down into opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With opcode 000000 and funct 100000, `result_o` shows (rs + rt) mod 2^DATA_W, and that value is written to register rd at the next rising edge.
- R2: With opcode 000000 and funct 100010, `result_o` shows (rs − rt) mod 2^DATA_W, and that value is written to rd at the next rising edge.
- R3: For an add, `carry_o` is the carry out of rs + rt. For a subtract, which is computed as rs + ~rt + 1, `carry_o` is 1 exactly when rs ≥ rt taken as unsigned values.
- R4: The shamt field has no effect on the result, the carry or the register write of an add or subtract.
- R5: A word whose opcode is not 000000, or whose funct is neither 100000 nor 100010, writes no register and drives `result_o` and `carry_o` to zero.
- R6: Register 0 always reads as zero, whatever its entry in the initial-value parameter holds, and a write addressed to it is discarded.
- R7: When `rst` is low at a rising edge, `pc_o` advances by one. It wraps from 2^PC_W − 1 back to 0.
- R8: When `rst` is high at a rising edge, `pc_o` becomes 0 and every register 1 to 31 is reloaded from its slice of REG_INIT (register i at bits [i·DATA_W +: DATA_W]). The first instruction after reset is fetched from address 0.
- R9: `result_o` and `carry_o` follow the instruction at the current `pc_o` during the same cycle. A register written by one instruction shows its new value to the instruction that comes right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | PC_W | Address of the instruction now executing |
| result_o | output | DATA_W | Value being produced by the current instruction, zero if the word is not a legal add or subtract |
| carry_o | output | 1 | Carry out of the add/subtract chain, zero if the word is not legal |

## Verification
The bench builds the core with its default DATA_W of 4 and PC_W of 4. With these values the program counter wraps every sixteen cycles and every sum and difference can overflow its 4-bit range, so carry, borrow and wrap-around cases occur often. The bench passes in a sixteen-word program. Eight words are fixed by hand to reach writes to register 0, reads of register 0, illegal opcodes and functs, a full shamt field and back-to-back dependent instructions. The other eight words come from a shift-register generator with a fixed seed. The bench also passes a register image whose entry for register 0 is nonzero, so a core that fails to ignore that entry gives a wrong result. Resets arrive at random points from a seeded generator, so the core is reloaded in the middle of a pass through the program as well as at its start.

// File: rtl/rtcore_pkg.sv
package rtcore_pkg;

   localparam int WORD_W   = 32;
   localparam int RIDX_W   = 5;
   localparam int NUM_REGS = 1 << RIDX_W;

   localparam logic [5:0] OPC_REG3 = 6'b000000;
   localparam logic [5:0] FN_ADD   = 6'b100000;
   localparam logic [5:0] FN_SUB   = 6'b100010;

   typedef struct packed {
      logic [5:0]        opc;
      logic [RIDX_W-1:0] src_a;
      logic [RIDX_W-1:0] src_b;
      logic [RIDX_W-1:0] dst;
      logic [4:0]        shift;
      logic [5:0]        fn;
   } iword_t;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2
   } alu_op_e;

endpackage

// File: rtl/rt_prog_rom.sv
module rt_prog_rom #(
   parameter int PC_W = 4,
   parameter int DEPTH = 1 << PC_W,
   parameter logic [DEPTH*rtcore_pkg::WORD_W-1:0] IMAGE = '0
) (
   input  logic [PC_W-1:0]                addr,
   output logic [rtcore_pkg::WORD_W-1:0]  word
);
   localparam int WW = rtcore_pkg::WORD_W;

   logic [WW-1:0] mem [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      assign mem[gi] = IMAGE[gi*WW +: WW];
   end

   assign word = mem[addr];
endmodule

// File: rtl/rt_decode.sv
module rt_decode
   import rtcore_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output alu_op_e           op,
   output logic              legal,
   output logic [RIDX_W-1:0] ra_idx,
   output logic [RIDX_W-1:0] rb_idx,
   output logic [RIDX_W-1:0] wr_idx,
   output logic [4:0]        shift_amt
);
   iword_t iw;
   assign iw = iword_t'(word);

   always_comb begin
      op = OP_NONE;
      if (iw.opc == OPC_REG3) begin
         unique case (iw.fn)
            FN_ADD:  op = OP_ADD;
            FN_SUB:  op = OP_SUB;
            default: op = OP_NONE;
         endcase
      end
   end

   assign legal     = (op != OP_NONE);
   assign ra_idx    = iw.src_a;
   assign rb_idx    = iw.src_b;
   assign wr_idx    = iw.dst;
   assign shift_amt = iw.shift;
endmodule

// File: rtl/rt_regfile.sv
module rt_regfile #(
   parameter int DATA_W = 4,
   parameter int IDX_W  = 5,
   parameter int NREGS  = 1 << IDX_W,
   parameter logic [NREGS*DATA_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_a_val,
   output logic [DATA_W-1:0] rd_b_val,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_val
);
   logic [DATA_W-1:0] cells [1:NREGS-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 1; k < NREGS; k++) begin
            cells[k] <= INIT[k*DATA_W +: DATA_W];
         end
      end else if (wr_en && (wr_idx != '0)) begin
         cells[wr_idx] <= wr_val;
      end
   end

   assign rd_a_val = (rd_a_idx == '0) ? '0 : cells[rd_a_idx];
   assign rd_b_val = (rd_b_idx == '0) ? '0 : cells[rd_b_idx];
endmodule

// File: rtl/rt_ripple_addsub.sv
module rt_ripple_addsub #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0]   chain;
   logic [W-1:0] b_eff;

   assign chain[0] = sub;

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      assign b_eff[gi]    = b[gi] ^ sub;
      assign sum[gi]      = a[gi] ^ b_eff[gi] ^ chain[gi];
      assign chain[gi+1]  = (a[gi] & b_eff[gi]) | (chain[gi] & (a[gi] ^ b_eff[gi]));
   end

   assign cout = chain[W];
endmodule

// File: rtl/rtcore_addsub.sv
module rtcore_addsub
   import rtcore_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int PC_W   = 4,
   parameter logic [(1<<PC_W)*WORD_W-1:0] ROM_IMAGE = '0,
   parameter logic [NUM_REGS*DATA_W-1:0]  REG_INIT  = '0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   pc_o,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   localparam int ROM_DEPTH = 1 << PC_W;

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
      $error("rtcore_addsub: DATA_W must lie in 1..32");
   end
   if (PC_W < 1 || PC_W > 8) begin : g_bad_pc_w
      $error("rtcore_addsub: PC_W must lie in 1..8");
   end

   logic [PC_W-1:0]   pc_q;
   logic [WORD_W-1:0] cur_word;
   alu_op_e           dec_op;
   logic              dec_legal;
   logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
   logic [4:0]        dec_shamt;
   logic [DATA_W-1:0] rs_val, rt_val;
   logic [DATA_W-1:0] alu_sum;
   logic              alu_cout;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_q + 1'b1;
   end

   rt_prog_rom #(
      .PC_W  (PC_W),
      .DEPTH (ROM_DEPTH),
      .IMAGE (ROM_IMAGE)
   ) u_rom (
      .addr (pc_q),
      .word (cur_word)
   );

   rt_decode u_dec (
      .word      (cur_word),
      .op        (dec_op),
      .legal     (dec_legal),
      .ra_idx    (rs_idx),
      .rb_idx    (rt_idx),
      .wr_idx    (rd_idx),
      .shift_amt (dec_shamt)
   );

   rt_regfile #(
      .DATA_W (DATA_W),
      .IDX_W  (RIDX_W),
      .NREGS  (NUM_REGS),
      .INIT   (REG_INIT)
   ) u_rf (
      .clk      (clk),
      .rst      (rst),
      .rd_a_idx (rs_idx),
      .rd_b_idx (rt_idx),
      .rd_a_val (rs_val),
      .rd_b_val (rt_val),
      .wr_en    (dec_legal),
      .wr_idx   (rd_idx),
      .wr_val   (alu_sum)
   );

   rt_ripple_addsub #(
      .W (DATA_W)
   ) u_alu (
      .a    (rs_val),
      .b    (rt_val),
      .sub  (dec_op == OP_SUB),
      .sum  (alu_sum),
      .cout (alu_cout)
   );

   assign pc_o     = pc_q;
   assign result_o = dec_legal ? alu_sum : '0;
   assign carry_o  = dec_legal & alu_cout;
endmodule

// File: rtl/rtcore_addsub_chk.sv
module rtcore_addsub_chk
   import rtcore_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int PC_W   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   pc,
   input logic [DATA_W-1:0] result,
   input logic              carry,
   input alu_op_e           op,
   input logic [RIDX_W-1:0] rs_idx,
   input logic [RIDX_W-1:0] rt_idx,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic [4:0]        shamt
);
   localparam int XW = DATA_W + 1;

   logic [XW-1:0] want_add, want_sub;
   assign want_add = {1'b0, rs_val} + {1'b0, rt_val};
   assign want_sub = {1'b0, rs_val} + {1'b0, ~rt_val} + XW'(1);

   AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ADD) |-> ({carry, result} == want_add)); // R1
   AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SUB) |-> (result == (rs_val - rt_val) && carry == (rs_val >= rt_val))); // R2
   AST_SHAMT_BLIND: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ADD && shamt != 5'd0) |-> ({carry, result} == want_add)); // R4
   AST_SUB_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SUB) |-> ({carry, result} == want_sub)); // R3
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
      (op == OP_NONE) |-> (result == '0 && !carry)); // R5
   AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
      (rs_idx == '0) |-> (rs_val == '0)); // R6
   AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
      (rt_idx == '0) |-> (rt_val == '0)); // R6
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (pc == $past(pc) + 1'b1)); // R7
   AST_PC_RESET: assert property (@(posedge clk)
      rst |=> (pc == '0)); // R8
endmodule

bind rtcore_addsub rtcore_addsub_chk #(
   .DATA_W (DATA_W),
   .PC_W   (PC_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pc     (pc_o),
   .result (result_o),
   .carry  (carry_o),
   .op     (dec_op),
   .rs_idx (rs_idx),
   .rt_idx (rt_idx),
   .rs_val (rs_val),
   .rt_val (rt_val),
   .shamt  (dec_shamt)
);

// File: tb/tb_rtcore_addsub.sv
module tb_rtcore_addsub;
   localparam int DW    = 4;
   localparam int PW    = 4;
   localparam int DEPTH = 1 << PW;
   localparam int NREG  = 32;

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [4:0] rd,
                                      input logic [4:0] sh, input logic [5:0] fn);
      return {opc, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [DEPTH*32-1:0] build_rom();
      logic [DEPTH*32-1:0] img;
      logic [15:0] s;
      logic [5:0] opc, fn;
      logic [4:0] rs, rt, rd, sh;
      img = '0;
      img[0*32 +: 32] = mk(6'b000000, 5'd2,  5'd4,  5'd3,  5'd0,  6'b100000);
      img[1*32 +: 32] = mk(6'b000000, 5'd3,  5'd9,  5'd5,  5'd0,  6'b100010);
      img[2*32 +: 32] = mk(6'b000000, 5'd7,  5'd8,  5'd0,  5'd0,  6'b100000);
      img[3*32 +: 32] = mk(6'b000000, 5'd0,  5'd5,  5'd6,  5'd0,  6'b100000);
      img[4*32 +: 32] = mk(6'b000001, 5'd6,  5'd6,  5'd5,  5'd0,  6'b100000);
      img[5*32 +: 32] = mk(6'b000000, 5'd6,  5'd5,  5'd6,  5'd0,  6'b100100);
      img[6*32 +: 32] = mk(6'b000000, 5'd6,  5'd6,  5'd10, 5'd31, 6'b100000);
      img[7*32 +: 32] = mk(6'b000000, 5'd1,  5'd31, 5'd11, 5'd7,  6'b100010);
      s = 16'hACE1;
      for (int k = 8; k < DEPTH; k++) begin
         for (int j = 0; j < 24; j++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
         rs  = s[4:0];
         rt  = s[9:5];
         rd  = s[14:10];
         for (int j = 0; j < 11; j++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
         sh  = s[4:0];
         fn  = (s[7:5] == 3'd0) ? 6'b100101 : (s[8] ? 6'b100010 : 6'b100000);
         opc = (s[11:9] == 3'd7) ? 6'b100011 : 6'b000000;
         img[k*32 +: 32] = mk(opc, rs, rt, rd, sh, fn);
      end
      return img;
   endfunction

   function automatic logic [NREG*DW-1:0] build_init();
      logic [NREG*DW-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*DW +: DW] = DW'((i * 5 + 3) % 16);
      v[0 +: DW] = 4'hA;
      return v;
   endfunction

   localparam logic [DEPTH*32-1:0] TB_ROM  = build_rom();
   localparam logic [NREG*DW-1:0]  TB_INIT = build_init();

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [PW-1:0] pc_o;
   logic [DW-1:0] result_o;
   logic          carry_o;

   always #10 clk = ~clk;

   rtcore_addsub #(
      .DATA_W    (DW),
      .PC_W      (PW),
      .ROM_IMAGE (TB_ROM),
      .REG_INIT  (TB_INIT)
   ) dut (
      .clk      (clk),
      .rst      (rst),
      .pc_o     (pc_o),
      .result_o (result_o),
      .carry_o  (carry_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] m_regs [NREG];
   logic [PW-1:0] m_pc;
   bit            m_valid = 0;
   bit            m_fresh = 0;
   bit            prev_wr = 0;
   logic [4:0]    prev_rd = '0;
   logic [DW-1:0] e_res;
   logic          e_cy;
   bit            e_legal;
   logic [4:0]    e_rd;

   task automatic check(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (pc %0d)", req, what, act, exp, m_pc);
      end
   endtask

   task automatic eval_model();
      logic [31:0] w;
      logic [4:0] rs, rt, sh;
      logic [5:0] opc, fn;
      logic [DW-1:0] a, b;
      logic [DW:0] t;
      w   = TB_ROM[int'(m_pc)*32 +: 32];
      opc = w[31:26]; rs = w[25:21]; rt = w[20:16]; e_rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
      a = (rs == 0) ? '0 : m_regs[rs];
      b = (rt == 0) ? '0 : m_regs[rt];
      e_legal = (opc == 6'b000000) && (fn == 6'b100000 || fn == 6'b100010);
      e_res = '0; e_cy = 1'b0;
      if (e_legal) begin
         if (fn == 6'b100000) t = {1'b0, a} + {1'b0, b};
         else                 t = {1'b0, a} + {1'b0, ~b} + 5'd1;
         e_res = t[DW-1:0];
         e_cy  = t[DW];
      end
   endtask

   task automatic check_outputs();
      logic [31:0] w;
      string tag;
      eval_model();
      w = TB_ROM[int'(m_pc)*32 +: 32];
      check(m_fresh ? "R8" : "R7", "pc_o", 8'(pc_o), 8'(m_pc));
      if (!e_legal)                                         tag = "R5";
      else if (m_fresh)                                     tag = "R8";
      else if (prev_wr && prev_rd != 0 &&
               (w[25:21] == prev_rd || w[20:16] == prev_rd)) tag = "R9";
      else if (w[25:21] == 0 || w[20:16] == 0)              tag = "R6";
      else if (w[10:6] != 0)                                tag = "R4";
      else if (w[5:0] == 6'b100010)                         tag = "R2";
      else                                                  tag = "R1";
      check(tag, "result_o", 8'(result_o), 8'(e_res));
      check(e_legal ? "R3" : "R5", "carry_o", 8'(carry_o), 8'(e_cy));
   endtask

   task automatic model_edge(input bit r);
      if (r) begin
         m_pc = '0;
         for (int i = 0; i < NREG; i++) m_regs[i] = TB_INIT[i*DW +: DW];
         m_valid = 1; m_fresh = 1; prev_wr = 0;
      end else if (m_valid) begin
         eval_model();
         if (e_legal && e_rd != 0) m_regs[e_rd] = e_res;
         prev_wr = e_legal;
         prev_rd = e_rd;
         m_pc = m_pc + 1'b1;
         m_fresh = 0;
      end
   endtask

   task automatic cycle(input bit next_rst);
      @(negedge clk);
      if (m_valid) check_outputs();
      rst = next_rst;
      @(posedge clk);
      #1;
      model_edge(rst);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1;
      cycle(1'b1);
      cycle(1'b1);
      // first pass: directed words 0..7, then two full wraps (R7, R8, R9)
      for (int n = 0; n < 40; n++) cycle(1'b0);
      // reset in the middle of a pass, then random reset points
      cycle(1'b1);
      for (int n = 0; n < 3000; n++) cycle(($urandom % 97) == 0);
      @(negedge clk);
      if (m_valid) check_outputs();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule